// File: doc/BRIEF.md
# Memory Address Generator

This block produces the address for a small word-addressed memory from one of two sources. The first is a program counter that steps forward by one on selected clock edges, so that instructions are fetched in order. The second is a data pointer register that takes its value from the shared data bus. The processor uses it to read or write a data word at an arbitrary location.

A single select input decides which of the two registers drives the memory address. The program counter's value and an end-of-range flag from its incrementer are also brought out, so that the sequencing logic can watch them. The memory itself sits outside this block.

Top module: `mem_addr_gen`

## Requirements
- R1: A synchronous active-high reset (`rst` high at a rising clock edge) clears both the program counter and the data pointer to 0. Afterwards `pc_val` reads 0, and `mem_addr` reads 0 for either value of `sel_pc`.
- R2: With `rst` low and `pc_step` high at a rising edge, `pc_val` becomes its previous value plus one.
- R3: With `pc_step` low at a rising edge, `pc_val` keeps its value.
- R4: The program counter is `AW` bits wide (4 by default, 16 words). Stepping from the all-ones value (15) returns it to 0.
- R5: With `mar_load` high at a rising edge, the data pointer takes the value of `bus_in`. With `mar_load` low, a change on `bus_in` does not alter it. Both cases are observed through `mem_addr` while `sel_pc` is 0.
- R6: `mem_addr` equals `pc_val` while `sel_pc` is 1 and equals the data pointer while `sel_pc` is 0. It follows a change of `sel_pc` within the same cycle, with no clock edge in between.
- R7: `pc_last` is the carry out of the incrementer. It is 1 exactly when `pc_val` is all ones (15) and 0 otherwise.
- R8: Reset takes priority: at an edge where `rst` is high, `pc_step` and `mar_load` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | AW | Data bus value captured by the data pointer |
| mar_load | input | 1 | Load the data pointer from `bus_in` at the next edge |
| sel_pc | input | 1 | 1: program counter drives `mem_addr`; 0: data pointer drives it |
| pc_step | input | 1 | Advance the program counter at the next edge |
| mem_addr | output | AW | Memory address from the selected source |
| pc_val | output | AW | Current program counter value |
| pc_last | output | 1 | Incrementer carry out; high when the program counter is all ones |

## Verification
A program counter that skips, stalls or fails to wrap shows on `pc_val` one edge after the faulty step. A `pc_last` flag that is out of step with the counter is visible in that same cycle. A data pointer that loads when it should hold, or fails to load, can only be seen through `mem_addr` with `sel_pc` at 0, on the first cycle after the edge. For that reason the bench switches `sel_pc` low right after loads and bus changes. It also toggles `sel_pc` between edges, which exposes any register wrongly placed in the select path within the same cycle.

// File: rtl/mem_addr_gen_pkg.sv
package mem_addr_gen_pkg;

  parameter int unsigned ADDR_W_DEF = 4;

  typedef enum logic {
    SRC_PTR = 1'b0,
    SRC_PC  = 1'b1
  } addr_src_e;

endpackage

// File: rtl/inc_chain.sv
module inc_chain #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] c;

  assign c[0] = 1'b1;

  // ripple of half adders, one per bit
  for (genvar i = 0; i < W; i++) begin : g_ha
    assign sum[i]  = a[i] ^ c[i];
    assign c[i+1]  = a[i] & c[i];
  end

  assign cout = c[W];

endmodule

// File: rtl/pc_counter.sv
module pc_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         at_last
);

  logic [W-1:0] nxt;

  inc_chain #(.W(W)) u_inc (
    .a    (count),
    .sum  (nxt),
    .cout (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      count <= nxt;
    end
  end

endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/addr_sel.sv
module addr_sel
  import mem_addr_gen_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  addr_src_e    src,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] ptr_in,
  output logic [W-1:0] addr
);

  always_comb begin
    case (src)
      SRC_PC:  addr = pc_in;
      default: addr = ptr_in;
    endcase
  end

endmodule

// File: rtl/mem_addr_gen.sv
module mem_addr_gen
  import mem_addr_gen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_in,
  input  logic          mar_load,
  input  logic          sel_pc,
  input  logic          pc_step,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] pc_val,
  output logic          pc_last
);

  logic [AW-1:0] ptr_q;
  addr_src_e     src;

  assign src = addr_src_e'(sel_pc);

  pc_counter #(.W(AW)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .step    (pc_step),
    .count   (pc_val),
    .at_last (pc_last)
  );

  ptr_reg #(.W(AW)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .load (mar_load),
    .d    (bus_in),
    .q    (ptr_q)
  );

  addr_sel #(.W(AW)) u_sel (
    .src    (src),
    .pc_in  (pc_val),
    .ptr_in (ptr_q),
    .addr   (mem_addr)
  );

endmodule

// File: rtl/mem_addr_gen_chk.sv
module mem_addr_gen_chk #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_in,
  input logic          mar_load,
  input logic          sel_pc,
  input logic          pc_step,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] pc_val,
  input logic          pc_last
);

  // R1 / R8: reset clears the counter regardless of other controls
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_val == '0));

  // R1 / R8: reset clears the pointer, seen on the address when it is selected
  a_r8_reset_ptr: assert property (@(posedge clk) (rst && !$isunknown(sel_pc)) |=> (sel_pc || mem_addr == '0));

  // R2 / R4: a step advances by one modulo 2**AW
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    pc_step |=> (pc_val == AW'($past(pc_val) + 1'b1)));

  // R3: no step, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_step |=> $stable(pc_val));

  // R5: load captures the bus, visible when the pointer is selected
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    mar_load |=> (sel_pc || mem_addr == $past(bus_in)));

  // R5: without load the pointer holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!mar_load && !sel_pc) |=> (sel_pc || $stable(mem_addr)));

  // R6: counter drives the address when selected
  a_r6_pc_path: assert property (@(posedge clk) disable iff (rst)
    sel_pc |-> (mem_addr == pc_val));

  // R7: carry flag tracks the all-ones counter value
  a_r7_last: assert property (@(posedge clk) disable iff (rst)
    pc_last == (pc_val == '1));

endmodule

bind mem_addr_gen mem_addr_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_mem_addr_gen.sv
module tb_mem_addr_gen;

  localparam int unsigned AW     = 4;
  localparam time         PERIOD = 10ns;
  localparam int unsigned NVEC   = 7;

  typedef struct packed {
    logic          rst;
    logic          sel;
    logic          ld;
    logic          step;
    logic [AW-1:0] data;
    logic [AW-1:0] e_addr;
    logic [AW-1:0] e_pc;
    logic          e_last;
  } vec_t;

  // expected values after the edge that follows each applied vector
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'h9, 4'h0, 4'h0, 1'b0}, // R8 reset wins
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h5, 4'h1, 4'h1, 1'b0}, // R2 step
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'hA, 4'h1, 4'h1, 1'b0}, // R3 hold, R5 load
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'h3, 4'hA, 4'h2, 1'b0}, // R5 ignore bus, R6
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'h7, 4'h7, 4'h3, 1'b0}, // R5 reload
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 4'h4, 4'h4, 1'b0}, // R6 pc path
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'h7, 4'h4, 1'b0}  // R3, R5 hold
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_in;
  logic          mar_load;
  logic          sel_pc;
  logic          pc_step;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] pc_val;
  logic          pc_last;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  mem_addr_gen #(.AW(AW)) dut (
    .clk      (clk),
    .rst      (rst),
    .bus_in   (bus_in),
    .mar_load (mar_load),
    .sel_pc   (sel_pc),
    .pc_step  (pc_step),
    .mem_addr (mem_addr),
    .pc_val   (pc_val),
    .pc_last  (pc_last)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_in = '0; mar_load = 1'b0; sel_pc = 1'b1; pc_step = 1'b0;
    edge_then_sample();
    check("R1 pc after reset", pc_val, 0);
    check("R7 last after reset", pc_last, 0);
    sel_pc = 1'b0;
    #1;
    check("R1 ptr after reset", mem_addr, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      rst = VEC[i].rst; sel_pc = VEC[i].sel; mar_load = VEC[i].ld;
      pc_step = VEC[i].step; bus_in = VEC[i].data;
      edge_then_sample();
      check($sformatf("R6 vec%0d addr", i), mem_addr, VEC[i].e_addr);
      check($sformatf("R2 vec%0d pc", i), pc_val, VEC[i].e_pc);
      check($sformatf("R7 vec%0d last", i), pc_last, VEC[i].e_last);
    end

    // R6: select change between edges; pc=4, pointer=7
    @(negedge clk);
    pc_step = 1'b0; mar_load = 1'b0; sel_pc = 1'b1;
    #1;
    check("R6 comb sel pc", mem_addr, 4);
    sel_pc = 1'b0;
    #1;
    check("R6 comb sel ptr", mem_addr, 7);

    // R7 / R4: count up to all ones then wrap
    pc_step = 1'b1; sel_pc = 1'b1;
    for (int k = 0; k < 11; k++) begin
      edge_then_sample();
    end
    check("R7 pc at 15", pc_val, 15);
    check("R7 last at 15", pc_last, 1);
    edge_then_sample();
    check("R4 wrap to 0", pc_val, 0);
    check("R4 last after wrap", pc_last, 0);

    // R3 hold over several edges
    @(negedge clk);
    pc_step = 1'b0;
    edge_then_sample();
    edge_then_sample();
    check("R3 hold pc", pc_val, 0);

    // R1 / R8: reset mid-run with load and step asserted
    @(negedge clk);
    pc_step = 1'b1;
    edge_then_sample();
    @(negedge clk);
    rst = 1'b1; mar_load = 1'b1; bus_in = 4'hC; sel_pc = 1'b0;
    edge_then_sample();
    check("R8 ptr reset over load", mem_addr, 0);
    check("R1 pc reset over step", pc_val, 0);

    @(negedge clk);
    rst = 1'b0; mar_load = 1'b0; pc_step = 1'b0;
    edge_then_sample();
    check("R5 no load after reset", mem_addr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule